// File: doc/BRIEF.md
# DMA Width-Converting Packing FIFO

This block is the staging buffer that sits inside one DMA stream between the source-side read port and the destination-side write port. It holds a small number of 32-bit words, organised as byte lanes. It accepts source items of one, two or four bytes and hands destination items of its own width. Bytes keep their order end to end and are placed little-endian across the lanes, so any mix of source and destination widths packs or unpacks correctly.

In buffered mode the block raises a destination request once the stored byte count reaches a programmable threshold. It also raises the request when the transfer is finishing and residual bytes remain. In direct mode the threshold is bypassed and every item passes straight through.

When the stream is enabled, the block checks that the threshold holds a whole number of destination bursts. If it does not, the block latches an error and keeps the stream disabled.

Top module: `dma_pack_fifo`

## Requirements
- R1: After reset the stream is disabled, the error flag is low, the byte count is zero, and `s_ready`, `d_valid` and `d_req` are low.
- R2: On an `en_req` cycle the stream becomes enabled only if the configuration is compatible; otherwise `fifo_err` sets and `stream_en` reads 0 from the next cycle. `en_clr` disables the stream and wins over `en_req`.
  - Compatible means direct mode is on, or threshold bytes modulo (beats × destination bytes) is zero.
  - Threshold bytes are (thr_sel+1)×4.
  - `burst_sel` codes 0/1/2/3 mean 1/4/8/16 beats.
  - Size codes 0/1/2 mean 1/2/4 bytes.
- R3: `fifo_err` is sticky. It is cleared by `err_clr` or `flush`. When `err_clr` coincides with a new error, the error wins.
- R4: Packing: the k-th byte written overall lands in lane (k mod destination bytes) of the destination item that carries it. Source lane i holds the i-th byte of a source item.
- R5: Unpacking preserves order: a wide source item is delivered low byte first over successive narrower destination items.
- R6: `s_ready` is high only while enabled and not flushing. In buffered mode it also needs free bytes ≥ source item bytes. In direct mode it also needs the buffer to be empty.
- R7: `fill_band` equals the byte count divided by 4, so 0..4 stands for empty, quarter, half, three-quarter and full.
- R8: `d_req` is high only while enabled and not flushing. In direct mode it equals `d_valid`. In buffered mode it is high when count ≥ threshold bytes, or when `xfer_done` is high with a nonzero count.
- R9: `d_valid` is high when count ≥ destination bytes, or when `xfer_done` is high with a nonzero count (never during flush).
  - A pop removes min(count, destination bytes).
  - Lanes at or above that number read as zero.
- R10: A write and a pop in the same cycle both take effect; the count moves by the bytes written minus the bytes popped.
- R11: `flush` clears the count, both byte pointers and the error flag in one cycle, and any write offered during it is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of contents and error |
| en_req | input | 1 | Request to enable the stream (runs the check) |
| en_clr | input | 1 | Disable the stream |
| err_clr | input | 1 | Clear the sticky error |
| direct_mode | input | 1 | 1 = bypass threshold accumulation |
| thr_sel | input | 2 | Threshold: 0..3 = 1..4 words |
| burst_sel | input | 2 | Destination burst: 1/4/8/16 beats |
| src_size | input | 2 | Source item size code |
| dst_size | input | 2 | Destination item size code |
| s_valid | input | 1 | Source item offered |
| s_data | input | 32 | Source item, byte 0 in lane 0 |
| s_ready | output | 1 | Source item accepted when high with s_valid |
| d_pop | input | 1 | Destination takes an item |
| d_valid | output | 1 | Destination item available |
| d_data | output | 32 | Destination item, zero-padded lanes |
| d_req | output | 1 | Destination service request |
| xfer_done | input | 1 | Transfer ending, drain residual bytes |
| stream_en | output | 1 | Stream enabled |
| fifo_err | output | 1 | Configuration error, sticky |
| fill_band | output | 3 | Fill level in quarters |

## Verification
A source write and a destination pop can land in the same cycle, and the count, the pointers and the band must reflect both. The bench provokes this by streaming every pairing of source and destination width with pops issued on two of every three cycles while writes continue. It judges the band, data and request against a byte-queue model, and tags the cycle after a double transfer as R10. A new configuration error can also coincide with an error clear; this is forced directly and the flag must stay set.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } item_size_e;

   typedef enum logic [1:0] {
      BL_ONE = 2'd0,
      BL_B4  = 2'd1,
      BL_B8  = 2'd2,
      BL_B16 = 2'd3
   } burst_len_e;

   function automatic logic [4:0] burst_beats(input logic [1:0] code);
      case (burst_len_e'(code))
         BL_ONE:  return 5'd1;
         BL_B4:   return 5'd4;
         BL_B8:   return 5'd8;
         default: return 5'd16;
      endcase
   endfunction
endpackage

// File: rtl/dpf_cfg_check.sv
module dpf_cfg_check #(
   parameter int DEPTH_B = 16,
   parameter int CNT_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             en_req,
   input  logic             en_clr,
   input  logic             err_clr,
   input  logic             direct_mode,
   input  logic [1:0]       thr_sel,
   input  logic [1:0]       burst_sel,
   input  logic [CNT_W-1:0] dst_nb,
   output logic [CNT_W-1:0] thr_nb,
   output logic             stream_en,
   output logic             fifo_err
);
   import dpf_pkg::*;

   localparam int QUARTER = DEPTH_B / 4;
   localparam int BW      = CNT_W + 5;

   logic [BW-1:0] burst_nb;
   logic          cfg_ok;
   logic          en_q;
   logic          err_q;

   always_comb begin
      case (thr_sel)
         2'd0:    thr_nb = CNT_W'(QUARTER);
         2'd1:    thr_nb = CNT_W'(2 * QUARTER);
         2'd2:    thr_nb = CNT_W'(3 * QUARTER);
         default: thr_nb = CNT_W'(DEPTH_B);
      endcase
      burst_nb = BW'(burst_beats(burst_sel)) * BW'(dst_nb);
      cfg_ok   = direct_mode || ((BW'(thr_nb) % burst_nb) == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         err_q <= 1'b0;
      end else begin
         if (en_clr)      en_q <= 1'b0;
         else if (en_req) en_q <= cfg_ok;

         if (flush)                  err_q <= 1'b0;
         else if (en_req && !cfg_ok) err_q <= 1'b1;
         else if (err_clr)           err_q <= 1'b0;
      end
   end

   assign stream_en = en_q;
   assign fifo_err  = err_q;

   AST_ERR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> !en_q); // R2
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !err_clr && !flush) |=> err_q); // R3
endmodule

// File: rtl/dpf_byte_store.sv
module dpf_byte_store #(
   parameter int LANES   = 4,
   parameter int DEPTH_B = 16,
   parameter int PTR_W   = 4,
   parameter int CNT_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               wr_fire,
   input  logic [CNT_W-1:0]   wr_nb,
   input  logic [8*LANES-1:0] wr_data,
   input  logic               rd_fire,
   input  logic [CNT_W-1:0]   rd_show,
   output logic [8*LANES-1:0] rd_data
);
   logic [7:0]       mem [DEPTH_B];
   logic [PTR_W-1:0] wp;
   logic [PTR_W-1:0] rp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else if (flush) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (wr_fire) wp <= wp + PTR_W'(wr_nb);
         if (rd_fire) rp <= rp + PTR_W'(rd_show);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_fire && !flush) begin
         for (int i = 0; i < LANES; i++) begin
            if (CNT_W'(i) < wr_nb) mem[wp + PTR_W'(i)] <= wr_data[8*i +: 8];
         end
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_rd_lane
      assign rd_data[8*g +: 8] = (CNT_W'(g) < rd_show) ? mem[rp + PTR_W'(g)] : 8'h00;
   end
endmodule

// File: rtl/dpf_level.sv
module dpf_level #(
   parameter int DEPTH_B = 16,
   parameter int CNT_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_fire,
   input  logic [CNT_W-1:0] wr_nb,
   input  logic             rd_fire,
   input  logic [CNT_W-1:0] rd_nb,
   output logic [CNT_W-1:0] count,
   output logic [2:0]       band
);
   localparam int QUARTER = DEPTH_B / 4;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (flush) cnt_q <= '0;
      else            cnt_q <= cnt_q + (wr_fire ? wr_nb : '0) - (rd_fire ? rd_nb : '0);
   end

   assign count = cnt_q;
   assign band  = 3'(cnt_q / CNT_W'(QUARTER));

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) <= DEPTH_B); // R10
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |-> (int'(cnt_q) + int'(wr_nb) <= DEPTH_B)); // R6
   AST_POP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire |-> (rd_nb <= cnt_q && rd_nb != '0)); // R9
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> cnt_q == '0); // R11
endmodule

// File: rtl/dma_pack_fifo.sv
module dma_pack_fifo #(
   parameter int LANES = 4,
   parameter int WORDS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               en_req,
   input  logic               en_clr,
   input  logic               err_clr,
   input  logic               direct_mode,
   input  logic [1:0]         thr_sel,
   input  logic [1:0]         burst_sel,
   input  logic [1:0]         src_size,
   input  logic [1:0]         dst_size,
   input  logic               s_valid,
   input  logic [8*LANES-1:0] s_data,
   output logic               s_ready,
   input  logic               d_pop,
   output logic               d_valid,
   output logic [8*LANES-1:0] d_data,
   output logic               d_req,
   input  logic               xfer_done,
   output logic               stream_en,
   output logic               fifo_err,
   output logic [2:0]         fill_band
);
   localparam int         DEPTH_B = LANES * WORDS;
   localparam int         PTR_W   = $clog2(DEPTH_B);
   localparam int         CNT_W   = $clog2(DEPTH_B + 1);
   localparam logic [1:0] SZ_MAX  = 2'($clog2(LANES));

   if (LANES < 1 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two");
   end
   if (WORDS < 4 || (WORDS % 4) != 0) begin : g_bad_words
      $error("WORDS must be a positive multiple of four");
   end

   function automatic logic [CNT_W-1:0] size_nb(input logic [1:0] code);
      return (code >= SZ_MAX) ? CNT_W'(LANES) : (CNT_W'(1) << code);
   endfunction

   logic [CNT_W-1:0] src_nb, dst_nb, thr_nb, count, free_nb, show_nb;
   logic             has_res, wr_fire, rd_fire;

   assign src_nb  = size_nb(src_size);
   assign dst_nb  = size_nb(dst_size);
   assign free_nb = CNT_W'(DEPTH_B) - count;
   assign show_nb = (count < dst_nb) ? count : dst_nb;
   assign has_res = xfer_done && (count != '0);

   assign s_ready = stream_en && !flush &&
                    (direct_mode ? (count == '0) : (free_nb >= src_nb));
   assign d_valid = !flush && ((count >= dst_nb) || has_res);
   assign d_req   = stream_en && !flush &&
                    (direct_mode ? d_valid : ((count >= thr_nb) || has_res));
   assign wr_fire = s_valid && s_ready;
   assign rd_fire = d_pop && d_valid;

   dpf_cfg_check #(.DEPTH_B(DEPTH_B), .CNT_W(CNT_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .flush(flush), .en_req(en_req), .en_clr(en_clr),
      .err_clr(err_clr), .direct_mode(direct_mode), .thr_sel(thr_sel),
      .burst_sel(burst_sel), .dst_nb(dst_nb), .thr_nb(thr_nb),
      .stream_en(stream_en), .fifo_err(fifo_err)
   );

   dpf_byte_store #(.LANES(LANES), .DEPTH_B(DEPTH_B), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_fire(wr_fire), .wr_nb(src_nb),
      .wr_data(s_data), .rd_fire(rd_fire), .rd_show(show_nb), .rd_data(d_data)
   );

   dpf_level #(.DEPTH_B(DEPTH_B), .CNT_W(CNT_W)) u_level (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_fire(wr_fire), .wr_nb(src_nb),
      .rd_fire(rd_fire), .rd_nb(show_nb), .count(count), .band(fill_band)
   );

   AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      d_req |-> stream_en); // R8
endmodule

// File: tb/dma_pack_fifo_tb.sv
module dma_pack_fifo_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0, rst_n = 0;
   logic        fl = 0, erq = 0, ecl = 0, ecr = 0, dir = 0, sv = 0, pop = 0, xend = 0;
   logic [1:0]  thr = 0, bst = 0, ssz = 2, dsz = 2;
   logic [31:0] sd = 0;
   logic        s_ready, d_valid, d_req, stream_en, fifo_err;
   logic [31:0] d_data;
   logic [2:0]  fill_band;

   int   nchk = 0, nerr = 0;
   logic [7:0] mq [16];
   int   mh = 0, mc = 0;
   logic en_m = 0, err_m = 0, both_prev = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_pack_fifo u_dut (
      .clk(clk), .rst_n(rst_n), .flush(fl), .en_req(erq), .en_clr(ecl), .err_clr(ecr),
      .direct_mode(dir), .thr_sel(thr), .burst_sel(bst), .src_size(ssz), .dst_size(dsz),
      .s_valid(sv), .s_data(sd), .s_ready(s_ready), .d_pop(pop), .d_valid(d_valid),
      .d_data(d_data), .d_req(d_req), .xfer_done(xend), .stream_en(stream_en),
      .fifo_err(fifo_err), .fill_band(fill_band)
   );

   task automatic chk(string r, logic [31:0] a, logic [31:0] e);
      nchk++;
      if (a !== e) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", r, a, e);
      end
   endtask

   task automatic cyc();
      int snb, dnb, thrb, show, beats;
      logic er, ev, eq, ok, wf, rf;
      logic [31:0] ed;
      snb = 1 << ssz; dnb = 1 << dsz; thrb = (int'(thr) + 1) * 4;
      beats = (bst == 0) ? 1 : (2 << bst);
      #1;
      show = (mc < dnb) ? mc : dnb;
      ed = 0;
      for (int i = 0; i < show; i++) ed[8*i +: 8] = mq[(mh + i) % 16];
      er = en_m && !fl && (dir ? (mc == 0) : (16 - mc >= snb));
      ev = !fl && (mc >= dnb || (xend && mc > 0));
      eq = en_m && !fl && (dir ? ev : (mc >= thrb || (xend && mc > 0)));
      chk("R6 s_ready", {31'b0, s_ready}, {31'b0, er});
      chk("R9 d_valid", {31'b0, d_valid}, {31'b0, ev});
      chk(snb < dnb ? "R4 d_data" : "R5 d_data", d_data, ed);
      chk("R8 d_req", {31'b0, d_req}, {31'b0, eq});
      chk(both_prev ? "R10 fill_band" : "R7 fill_band", {29'b0, fill_band}, mc / 4);
      chk("R2 stream_en", {31'b0, stream_en}, {31'b0, en_m});
      chk("R3 fifo_err", {31'b0, fifo_err}, {31'b0, err_m});
      wf = sv && er; rf = pop && ev;
      both_prev = wf && rf;
      if (fl) begin
         mc = 0; mh = 0;
      end else begin
         if (rf) begin mh = (mh + show) % 16; mc -= show; end
         if (wf) begin
            for (int i = 0; i < snb; i++) mq[(mh + mc + i) % 16] = sd[8*i +: 8];
            mc += snb;
         end
      end
      ok = dir || ((thrb % (beats * dnb)) == 0);
      if (ecl) en_m = 0; else if (erq) en_m = ok;
      if (fl) err_m = 0; else if (erq && !ok) err_m = 1; else if (ecr) err_m = 0;
      @(posedge clk); @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 3);
      @(negedge clk); rst_n = 1;
      #1;
      chk("R1 stream_en", {31'b0, stream_en}, 0);
      chk("R1 fifo_err", {31'b0, fifo_err}, 0);
      chk("R1 s_ready", {31'b0, s_ready}, 0);
      chk("R1 d_valid", {31'b0, d_valid}, 0);
      chk("R1 d_req", {31'b0, d_req}, 0);
      chk("R1 fill_band", {29'b0, fill_band}, 0);
      @(negedge clk);

      // R2 / R3: compatibility sweep at enable
      for (int d = 0; d < 2; d++)
         for (int t = 0; t < 4; t++)
            for (int b = 0; b < 4; b++)
               for (int z = 0; z < 3; z++) begin
                  dir = d[0]; thr = t[1:0]; bst = b[1:0]; dsz = z[1:0];
                  erq = 1; cyc(); erq = 0;
                  cyc();
                  ecr = 1; ecl = 1; cyc(); ecr = 0; ecl = 0;
               end

      // R3: new error wins over a simultaneous clear, flush clears it
      dir = 0; thr = 0; bst = 3; dsz = 2;
      erq = 1; ecr = 1; cyc(); erq = 0; ecr = 0;
      cyc();
      fl = 1; cyc(); fl = 0;
      cyc();

      // R4 R5 R7 R8 R9 R10: width pairings under streaming
      bst = 0;
      for (int s = 0; s < 3; s++)
         for (int z = 0; z < 3; z++)
            for (int t = 0; t < 4; t++) begin
               ssz = s[1:0]; dsz = z[1:0]; thr = t[1:0];
               fl = 1; cyc(); fl = 0;
               erq = 1; cyc(); erq = 0;
               for (int k = 0; k < 30; k++) begin
                  sv = (k < 20);
                  pop = (k >= 6) && (k % 3 != 0);
                  sd = {8'(k*5+s*16+z*3+3), 8'(k*5+s*16+z*3+2), 8'(k*5+s*16+z*3+1), 8'(k*5+s*16+z*3)};
                  cyc();
               end
               sv = 0; pop = 1; xend = 1;
               for (int k = 0; k < 12; k++) cyc();
               xend = 0; pop = 0;
               ecl = 1; cyc(); ecl = 0;
            end

      // R11: flush with a write offered
      dir = 0; thr = 3; ssz = 2; dsz = 2;
      erq = 1; cyc(); erq = 0;
      sv = 1; sd = 32'hA1B2C3D4;
      for (int k = 0; k < 3; k++) cyc();
      fl = 1; cyc(); fl = 0; sv = 0;
      #1;
      chk("R11 fill_band after flush", {29'b0, fill_band}, 0);
      chk("R11 d_valid after flush", {31'b0, d_valid}, 0);
      @(negedge clk);

      // R8 direct mode pass-through
      dir = 1;
      erq = 1; cyc(); erq = 0;
      for (int k = 0; k < 8; k++) begin
         sv = 1; pop = k[0]; sd = 32'h01020304 * (k + 1);
         cyc();
      end
      sv = 0; pop = 0;

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule